// File: doc/BRIEF.md
# Single-Carrier Multilevel PWM Comparator

This block produces the raw pulse train for one phase leg of an n-level flying-capacitor converter with a single triangular carrier. A signed fixed-point reference between -1 and +1 arrives with a sample strobe and is kept in a holding register. The block decides which of the n-1 equal voltage bands the reference occupies. It then shifts and scales the reference so that the occupied band spans the whole carrier range [0, 1]. That value is compared with an up/down counter carrier.

The outputs are the raw PWM bit, the active band number, and an interval number. The interval number steps at every carrier slope change, so a later mask stage can route the raw pulse to the correct converter cell. The reference input is a plain strobe with no back-pressure. A new strobe overwrites the held value, and nothing is queued. `LEVELS` must be at least 3.

Top module: `sc_level_pwm`

## Requirements
- R1: After reset the interval output is 1, the carrier is 0 and rising, and the band and scaled level are those of a zero reference (band 3 for five levels, with PWM high at the carrier valley).
- R2: The carrier counts 0..CAR_MAX..0 in steps of one per clock. The interval output advances by one on the clock edge that leaves a peak or a valley. It wraps from 2(LEVELS-1) back to 1, is odd while the carrier rises and is even while it falls.
- R3: The reference is two's complement of REF_W bits, with 1.0 equal to 2^(REF_W-2). With u = v+1, the band is floor(u(LEVELS-1)/2)+1, numbered 1 at the bottom. A value exactly on a band edge belongs to the upper band, and +1.0 gives band LEVELS-1.
- R4: A reference above +1.0 is treated as +1.0, and one below -1.0 is treated as -1.0.
- R5: The scaled level is r = u(LEVELS-1)/2 - (band-1). This equals (v + (LEVELS-2b+1)/(LEVELS-1))(LEVELS-1)/2 and always lies in [0, 1].
- R6: Raw PWM is 1 exactly when r·CAR_MAX >= carrier.
- R7: Band and scaled level change only on a peak or valley edge. They take the held reference, and a strobe between turns has no effect on any output until the next turn.
- R8: A strobe presented in the same cycle as a turn edge is used by that turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_stb | input | 1 | Loads ref_val into the holding register |
| ref_val | input | REF_W | Signed reference, 1.0 = 2^(REF_W-2) |
| pwm_o | output | 1 | Raw PWM |
| band_o | output | $clog2(LEVELS) | Active band, 1..LEVELS-1 |
| interval_o | output | $clog2(2(LEVELS-1)+1) | Carrier interval, 1..2(LEVELS-1) |

## Verification
A bad carrier direction or count shows within one half period: the interval parity no longer matches the slope, and the interval steps at the wrong cycle. A wrong band decision or offset shows at the next turn edge, where band_o differs or the pulse width changes on the following slope. A missing or extra latch shows as band_o moving between turns. The bench models the carrier, interval, band and level on every clock and compares all three outputs on every cycle. It uses directed band edges, out-of-range values and strobes aligned to the turn edge, together with seeded random references.

// File: rtl/scl_pwm_pkg.sv
package scl_pwm_pkg;
  typedef enum logic {SLOPE_DOWN = 1'b0, SLOPE_UP = 1'b1} slope_e;
endpackage

// File: rtl/scl_carrier.sv
module scl_carrier
  import scl_pwm_pkg::*;
#(
  parameter int CAR_MAX = 6098,
  parameter int SEGS    = 8,
  parameter int CAR_W   = $clog2(CAR_MAX + 1),
  parameter int INT_W   = $clog2(SEGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CAR_W-1:0] car_o,
  output slope_e           slope_o,
  output logic             turn_o,
  output logic [INT_W-1:0] interval_o
);
  localparam logic [CAR_W-1:0] TOP      = CAR_W'(CAR_MAX);
  localparam logic [CAR_W-1:0] BELOW    = CAR_W'(CAR_MAX - 1);
  localparam logic [INT_W-1:0] LAST_SEG = INT_W'(SEGS);

  // A turn happens on the edge that leaves a peak or a valley.
  assign turn_o = (slope_o == SLOPE_UP)   ? (car_o == TOP)
                                          : (car_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_o      <= '0;
      slope_o    <= SLOPE_UP;
      interval_o <= INT_W'(1);
    end else if (turn_o) begin
      if (slope_o == SLOPE_UP) begin
        slope_o <= SLOPE_DOWN;
        car_o   <= BELOW;
      end else begin
        slope_o <= SLOPE_UP;
        car_o   <= CAR_W'(1);
      end
      interval_o <= (interval_o == LAST_SEG) ? INT_W'(1) : interval_o + INT_W'(1);
    end else if (slope_o == SLOPE_UP) begin
      car_o <= car_o + CAR_W'(1);
    end else begin
      car_o <= car_o - CAR_W'(1);
    end
  end
endmodule

// File: rtl/scl_band_scale.sv
module scl_band_scale #(
  parameter int LEVELS = 5,
  parameter int REF_W  = 16,
  parameter int BAND_W = $clog2(LEVELS)
) (
  input  logic signed [REF_W-1:0] ref_i,
  output logic        [BAND_W-1:0] band_o,
  output logic        [REF_W-1:0]  depth_o
);
  localparam int NCMP = LEVELS - 2;
  localparam int SC_W = REF_W + BAND_W;
  localparam logic signed [REF_W-1:0] ONE_S = REF_W'(1 << (REF_W - 2));
  localparam logic signed [REF_W-1:0] NEG_S = -ONE_S;

  logic signed [REF_W-1:0] clamped;
  logic        [REF_W-1:0] u;
  logic        [SC_W-1:0]  scaled;
  logic        [NCMP-1:0]  hits;
  logic        [BAND_W-1:0] cnt;
  logic        [SC_W-1:0]  base;

  always_comb begin
    if (ref_i > ONE_S)      clamped = ONE_S;
    else if (ref_i < NEG_S) clamped = NEG_S;
    else                    clamped = ref_i;
  end

  // Shift to [0, 2.0] and scale by the number of bands.
  assign u      = REF_W'(clamped) + REF_W'(ONE_S);
  assign scaled = SC_W'(u) * SC_W'(LEVELS - 1);

  // One comparator per internal band edge; an edge hit lifts the band.
  for (genvar k = 1; k <= NCMP; k++) begin : g_edge
    localparam logic [SC_W-1:0] THR = SC_W'(k) << (REF_W - 1);
    assign hits[k-1] = (scaled >= THR);
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < NCMP; k++) cnt = cnt + BAND_W'(hits[k]);
  end

  assign band_o  = cnt + BAND_W'(1);
  assign base    = SC_W'(cnt) << (REF_W - 1);
  assign depth_o = REF_W'(scaled - base);
endmodule

// File: rtl/scl_level_cmp.sv
module scl_level_cmp #(
  parameter int REF_W   = 16,
  parameter int CAR_MAX = 6098,
  parameter int CAR_W   = $clog2(CAR_MAX + 1),
  parameter int BAND_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              turn_i,
  input  logic [CAR_W-1:0]  car_i,
  input  logic [BAND_W-1:0] band_i,
  input  logic [REF_W-1:0]  depth_i,
  input  logic [BAND_W-1:0] band_rst_i,
  input  logic [REF_W-1:0]  depth_rst_i,
  output logic [BAND_W-1:0] band_o,
  output logic              pwm_o
);
  localparam int LV_W = REF_W + CAR_W;

  logic [LV_W-1:0] level_q;
  logic [LV_W-1:0] car_scaled;

  // Level is depth scaled to carrier counts, kept at 2x full-scale resolution.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_o  <= band_rst_i;
      level_q <= LV_W'(depth_rst_i) * LV_W'(CAR_MAX);
    end else if (turn_i) begin
      band_o  <= band_i;
      level_q <= LV_W'(depth_i) * LV_W'(CAR_MAX);
    end
  end

  assign car_scaled = LV_W'(car_i) << (REF_W - 1);
  assign pwm_o      = (level_q >= car_scaled);
endmodule

// File: rtl/sc_level_pwm.sv
module sc_level_pwm
  import scl_pwm_pkg::*;
#(
  parameter int LEVELS  = 5,
  parameter int REF_W   = 16,
  parameter int CAR_MAX = 6098
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ref_stb,
  input  logic signed [REF_W-1:0]            ref_val,
  output logic                               pwm_o,
  output logic [$clog2(LEVELS)-1:0]          band_o,
  output logic [$clog2(2*(LEVELS-1)+1)-1:0]  interval_o
);
  localparam int SEGS   = 2 * (LEVELS - 1);
  localparam int BAND_W = $clog2(LEVELS);
  localparam int INT_W  = $clog2(SEGS + 1);
  localparam int CAR_W  = $clog2(CAR_MAX + 1);

  logic signed [REF_W-1:0] held_q;
  logic signed [REF_W-1:0] sel_ref;
  logic [CAR_W-1:0]        car_w;
  slope_e                  slope_w;
  logic                    turn_w;
  logic [BAND_W-1:0]       band_new, band_zero;
  logic [REF_W-1:0]        depth_new, depth_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (ref_stb) held_q <= ref_val;
  end

  // A strobe coinciding with a turn is taken by that turn.
  assign sel_ref = ref_stb ? ref_val : held_q;

  scl_carrier #(.CAR_MAX(CAR_MAX), .SEGS(SEGS), .CAR_W(CAR_W), .INT_W(INT_W)) u_car (
    .clk(clk), .rst_n(rst_n), .car_o(car_w), .slope_o(slope_w),
    .turn_o(turn_w), .interval_o(interval_o)
  );

  scl_band_scale #(.LEVELS(LEVELS), .REF_W(REF_W), .BAND_W(BAND_W)) u_scale (
    .ref_i(sel_ref), .band_o(band_new), .depth_o(depth_new)
  );

  // Same mapping of a zero reference gives the reset band and level.
  scl_band_scale #(.LEVELS(LEVELS), .REF_W(REF_W), .BAND_W(BAND_W)) u_zero (
    .ref_i('0), .band_o(band_zero), .depth_o(depth_zero)
  );

  scl_level_cmp #(.REF_W(REF_W), .CAR_MAX(CAR_MAX), .CAR_W(CAR_W), .BAND_W(BAND_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .turn_i(turn_w), .car_i(car_w),
    .band_i(band_new), .depth_i(depth_new),
    .band_rst_i(band_zero), .depth_rst_i(depth_zero),
    .band_o(band_o), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/scl_pwm_checks.sv
module scl_pwm_checks
  import scl_pwm_pkg::*;
#(
  parameter int LEVELS  = 5,
  parameter int CAR_MAX = 6098,
  parameter int CAR_W   = $clog2(CAR_MAX + 1),
  parameter int BAND_W  = $clog2(LEVELS),
  parameter int INT_W   = $clog2(2*(LEVELS-1)+1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CAR_W-1:0]  car,
  input slope_e            slope,
  input logic [INT_W-1:0]  interval,
  input logic [BAND_W-1:0] band,
  input logic              pwm
);
  localparam int SEGS = 2 * (LEVELS - 1);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assert_interval_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (interval >= INT_W'(1)) && (interval <= INT_W'(SEGS)));

  assert_interval_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slope == SLOPE_UP) == interval[0]);

  assert_interval_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && (interval != $past(interval)) |->
      (interval == (($past(interval) == INT_W'(SEGS)) ? INT_W'(1) : $past(interval) + INT_W'(1))));

  assert_carrier_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((car == $past(car) + CAR_W'(1)) || ($past(car) == car + CAR_W'(1))));

  assert_band_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (band >= BAND_W'(1)) && (band <= BAND_W'(LEVELS - 1)));

  assert_band_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && (band != $past(band)) |-> (interval != $past(interval)));

  assert_pwm_valley_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (car == '0) |-> pwm);
endmodule

bind sc_level_pwm scl_pwm_checks #(.LEVELS(LEVELS), .CAR_MAX(CAR_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .car(car_w), .slope(slope_w),
  .interval(interval_o), .band(band_o), .pwm(pwm_o)
);

// File: tb/sc_level_pwm_bench.sv
module sc_level_pwm_bench;
  localparam int LEVELS = 5;
  localparam int REF_W  = 16;
  localparam int M      = 12;
  localparam int ONE    = 1 << (REF_W - 2);
  localparam int SEGS   = 2 * (LEVELS - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_stb = 1'b0;
  logic signed [REF_W-1:0] ref_val = '0;
  logic pwm_o;
  logic [$clog2(LEVELS)-1:0] band_o;
  logic [$clog2(SEGS+1)-1:0] interval_o;

  always #10 clk = ~clk;

  sc_level_pwm #(.LEVELS(LEVELS), .REF_W(REF_W), .CAR_MAX(M)) u_sc_level_pwm (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .ref_val(ref_val),
    .pwm_o(pwm_o), .band_o(band_o), .interval_o(interval_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R6";

  // Model state
  int mc, mint, mband, mdepth, mheld;
  bit mup;

  function automatic int clampv(int v);
    if (v > ONE) return ONE;
    if (v < -ONE) return -ONE;
    return v;
  endfunction

  function automatic int band_of(int v);
    longint u = longint'(clampv(v)) + ONE;
    int b = int'((u * (LEVELS - 1)) / (2 * ONE)) + 1;
    if (b > LEVELS - 1) b = LEVELS - 1;
    return b;
  endfunction

  function automatic int depth_of(int v);
    longint u = longint'(clampv(v)) + ONE;
    return int'(u * (LEVELS - 1) - longint'(band_of(v) - 1) * 2 * ONE);
  endfunction

  function automatic bit pwm_exp();
    return (longint'(mdepth) * M) >= (longint'(mc) * 2 * ONE);
  endfunction

  function automatic bit turn_next();
    return (mup && mc == M) || (!mup && mc == 0);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk(interval_o == mint, "R2", int'(interval_o), mint);
    chk(band_o == mband, tag, int'(band_o), mband);
    chk(pwm_o == pwm_exp(), tag, int'(pwm_o), int'(pwm_exp()));
  endtask

  task automatic cycle(bit stb, int v);
    ref_stb = stb;
    ref_val = REF_W'(v);
    @(posedge clk);
    if (turn_next()) begin
      int s = stb ? v : mheld;
      mband  = band_of(s);
      mdepth = depth_of(s);
      mint   = (mint == SEGS) ? 1 : mint + 1;
      if (mup) begin mup = 0; mc = M - 1; end
      else     begin mup = 1; mc = 1; end
    end else begin
      mc = mup ? mc + 1 : mc - 1;
    end
    if (stb) mheld = v;
    @(negedge clk);
    ref_stb = 1'b0;
    check_outputs();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle(0, 0);
  endtask

  task automatic hold(int v, int n);
    cycle(1, v);
    run(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4021);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mc = 0; mup = 1; mint = 1; mheld = 0;
    mband = band_of(0); mdepth = depth_of(0);
    // R1: reset state, zero reference sits in band 3 with level 0
    chk(interval_o == 1, "R1", int'(interval_o), 1);
    chk(band_o == 3, "R1", int'(band_o), 3);
    chk(pwm_o == 1'b1, "R1", int'(pwm_o), 1);

    tag = "R6"; run(4 * M);

    // R3: band edges and neighbours
    tag = "R3";
    foreach (dirs[i]) hold(dirs[i], 2 * M + 2);

    // R4: out-of-range references
    tag = "R4";
    hold(32767, 2 * M + 2);
    hold(-32768, 2 * M + 2);
    hold(ONE + 1, 2 * M + 2);
    hold(-ONE - 1, 2 * M + 2);

    // R5: mid-band levels check the offset and gain
    tag = "R5";
    hold(-3 * ONE / 4, 2 * M + 2);
    hold(ONE / 4, 2 * M + 2);
    hold(ONE / 8 + 3, 2 * M + 2);

    // R7: strobes between turns must not move outputs
    tag = "R7";
    for (int i = 0; i < 40; i++) begin
      cycle(1, int'($urandom_range(2 * ONE)) - ONE);
      run(int'($urandom_range(5)));
    end

    // R8: strobe on the turning edge itself
    tag = "R8";
    for (int i = 0; i < 8; i++) begin
      hold(-ONE + 10, 1);
      while (!turn_next()) cycle(0, 0);
      cycle(1, (i % 2) ? ONE - 10 : ONE / 2 + 1);
      run(M + 2);
    end

    // R6: seeded random references with random gaps
    tag = "R6";
    for (int i = 0; i < 300; i++) begin
      cycle(1, int'($urandom_range(2 * ONE + 400)) - ONE - 200);
      run(int'($urandom_range(3 * M)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int dirs[10] = '{-ONE, -ONE / 2, -ONE / 2 - 1, 0, -1, ONE / 2, ONE / 2 - 1, ONE, ONE - 1, -ONE + 1};
endmodule